// File: doc/BRIEF.md
# 100BASE-TX Receive Symbol Decoder

This block sits at the end of a 100 Mb/s receive path. It takes one aligned and already descrambled 5-bit code group per receive clock and turns the stream into the four MII receive signals: a data nibble, data valid, receive error and carrier sense. It finds the start-of-stream pair J then K and the end-of-stream pair T then R, and it treats the all-ones code as idle. It maps the sixteen data code groups to nibbles and flags every symbol that does not fit where it arrives.

Carrier sense and data valid are driven by separate rules. Carrier follows the received symbols: any non-idle code raises it and idle drops it. Data valid covers only the span from J to the last data symbol. In NIC mode the local transmitter also holds carrier sense high. A repeater-mode input removes that contribution, so carrier then shows only received traffic. A bypass input skips the code-group decode and passes the raw low bits through.

A pair can only be recognised once its second symbol is in view. For that reason the decoder keeps one code group of history, and its outputs trail the input by two clock edges.

Top module: `rxsd_rx_decoder`

## Requirements
- R1: A code group on `rx_cg` at rising edge k is reflected on the outputs right after edge k+1. Inside a frame, the data code groups map to nibbles as 0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101, with data valid and carrier high and error low.
- R2: Outside a frame, J (11000) followed directly by K (10001) starts a frame. For both of those symbol times the output nibble is 5h, data valid is high and carrier is high; data valid rises on the J time.
- R3: Inside a frame, T (01101) followed directly by R (00111) ends it. Data valid is low on the T and R times, carrier stays high through both, and error stays low.
- R4: Idle (11111) outside a frame gives carrier, data valid and error all low. Any non-idle code group raises receive carrier.
- R5: Inside a frame, a code group that is not data and not a valid T/R pair gives error high, data valid high and nibble 0, and the frame continues. This covers J, K, R, an invalid code, or T in a position where it is invalid.
- R6: Outside a frame, a non-idle code group that does not begin a J-then-K pair gives error high, carrier high, data valid low and nibble 0. This includes J followed by anything other than K.
- R7: Idle inside a frame with no preceding T/R is a premature end. For that one symbol time it gives error high with data valid and receive carrier low, and the frame ends.
- R8: T inside a frame that is not followed by R is reported as an error with data valid held high, and the frame continues.
- R9: With `rptr_mode` low, `tx_active` high at an edge forces `mii_crs` high after that edge. With `rptr_mode` high, `tx_active` has no effect on `mii_crs`.
- R10: With `bypass_4b5b` high, the nibble is the low four bits of the code group and bit 4 is ignored. Data valid and carrier are high, error is low, and any frame in progress is abandoned.
- R11: While `rst_n` is low at an edge, all four MII outputs go low after that edge, and the stored code group becomes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz receive symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_cg | input | 5 | Aligned, descrambled code group, bit 4 first in line |
| tx_active | input | 1 | Local transmitter is sending |
| rptr_mode | input | 1 | 1 = repeater mode, 0 = NIC mode |
| bypass_4b5b | input | 1 | 1 = skip code-group decode |
| mii_rxd | output | 4 | Receive data nibble |
| mii_rx_dv | output | 1 | Receive data valid |
| mii_rx_er | output | 1 | Receive error |
| mii_crs | output | 1 | Carrier sense |

## Verification
The two functions that can land in the same cycle are the transmit term of carrier sense and the receive-side carrier decision. The sharpest case is a premature idle: it drops receive carrier while the transmitter is active. The bench drives `tx_active` through frames that contain premature ends and false carriers, once in NIC mode and once in repeater mode. Its model ORs the transmit term into the symbol-level carrier expectation for each cycle. The bench also switches `bypass_4b5b` on during an open frame, so that abandoning the frame and the raw pass-through fall on the same edge.

// File: rtl/rxsd_pkg.sv
// Shared constants, code-group kinds and the 4B/5B code functions
// used by the receive symbol decoder. Pure declarations, no state.
package rxsd_pkg;

    localparam int CG_W  = 5;
    localparam int NIB_W = 4;
    localparam int N_DATA = 1 << NIB_W;

    localparam logic [CG_W-1:0]  CG_IDLE = 5'b11111;
    localparam logic [CG_W-1:0]  CG_J    = 5'b11000;
    localparam logic [CG_W-1:0]  CG_K    = 5'b10001;
    localparam logic [CG_W-1:0]  CG_T    = 5'b01101;
    localparam logic [CG_W-1:0]  CG_R    = 5'b00111;
    localparam logic [NIB_W-1:0] NIB_SSD = 4'h5;

    typedef enum logic [2:0] {
        CK_DATA, CK_IDLE, CK_J, CK_K, CK_T, CK_R, CK_BAD
    } cg_kind_e;

    typedef struct packed {
        cg_kind_e         kind;
        logic [NIB_W-1:0] nib;
    } cg_info_t;

    // Data nibble to its 5-bit code group.
    function automatic logic [CG_W-1:0] cg_encode(input logic [NIB_W-1:0] nib);
        case (nib)
            4'h0: cg_encode = 5'b11110;
            4'h1: cg_encode = 5'b01001;
            4'h2: cg_encode = 5'b10100;
            4'h3: cg_encode = 5'b10101;
            4'h4: cg_encode = 5'b01010;
            4'h5: cg_encode = 5'b01011;
            4'h6: cg_encode = 5'b01110;
            4'h7: cg_encode = 5'b01111;
            4'h8: cg_encode = 5'b10010;
            4'h9: cg_encode = 5'b10011;
            4'hA: cg_encode = 5'b10110;
            4'hB: cg_encode = 5'b10111;
            4'hC: cg_encode = 5'b11010;
            4'hD: cg_encode = 5'b11011;
            4'hE: cg_encode = 5'b11100;
            default: cg_encode = 5'b11101;
        endcase
    endfunction

    // Code group to kind and nibble; the data search reuses cg_encode.
    function automatic cg_info_t cg_decode(input logic [CG_W-1:0] cg);
        cg_info_t r;
        r.nib = '0;
        case (cg)
            CG_IDLE: r.kind = CK_IDLE;
            CG_J:    r.kind = CK_J;
            CG_K:    r.kind = CK_K;
            CG_T:    r.kind = CK_T;
            CG_R:    r.kind = CK_R;
            default: r.kind = CK_BAD;
        endcase
        for (int i = 0; i < N_DATA; i++) begin
            if (cg_encode(NIB_W'(i)) == cg) begin
                r.kind = CK_DATA;
                r.nib  = NIB_W'(i);
            end
        end
        return r;
    endfunction

    function automatic cg_kind_e cg_kind_of(input logic [CG_W-1:0] cg);
        cg_info_t r;
        r = cg_decode(cg);
        return r.kind;
    endfunction

endpackage

// File: rtl/rxsd_cg_classify.sv
// Combinational classifier for one code group: kind plus data nibble.
// Assumes the code group is already aligned and descrambled.
module rxsd_cg_classify
    import rxsd_pkg::*;
(
    input  logic [CG_W-1:0]  cg,
    output cg_kind_e         kind,
    output logic [NIB_W-1:0] nib
);

    cg_info_t info;

    // Look the code group up in the 4B/5B set.
    always_comb begin
        info = cg_decode(cg);
        kind = info.kind;
        nib  = info.nib;
    end

endmodule

// File: rtl/rxsd_frame_fsm.sv
// Frame tracker: decides data valid, error, nibble and receive carrier
// for the held symbol, using the following symbol to recognise J/K and
// T/R pairs. Registered outputs; receive carrier is also exported
// unregistered so the top can merge the transmit term.
// Assumes cur_* describes the held symbol and nxt_kind the one arriving.
module rxsd_frame_fsm
    import rxsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  cg_kind_e         cur_kind,
    input  logic [NIB_W-1:0] cur_nib,
    input  logic [NIB_W-1:0] cur_raw,
    input  cg_kind_e         nxt_kind,
    output logic [NIB_W-1:0] rx_rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             car_next
);

    logic             in_frame, pend_k, pend_r;
    logic             in_frame_n, pend_k_n, pend_r_n;
    logic [NIB_W-1:0] rxd_n;
    logic             dv_n, er_n;

    // Symbol-level rules for the held code group.
    always_comb begin
        in_frame_n = in_frame;
        pend_k_n   = pend_k;
        pend_r_n   = pend_r;
        rxd_n      = '0;
        dv_n       = 1'b0;
        er_n       = 1'b0;
        car_next   = 1'b0;
        if (bypass) begin
            rxd_n      = cur_raw;
            dv_n       = 1'b1;
            car_next   = 1'b1;
            in_frame_n = 1'b0;
            pend_k_n   = 1'b0;
            pend_r_n   = 1'b0;
        end else if (pend_k) begin
            rxd_n    = NIB_SSD;
            dv_n     = 1'b1;
            car_next = 1'b1;
            pend_k_n = 1'b0;
        end else if (pend_r) begin
            car_next = 1'b1;
            pend_r_n = 1'b0;
        end else if (in_frame) begin
            case (cur_kind)
                CK_DATA: begin
                    rxd_n    = cur_nib;
                    dv_n     = 1'b1;
                    car_next = 1'b1;
                end
                CK_IDLE: begin
                    er_n       = 1'b1;
                    in_frame_n = 1'b0;
                end
                CK_T: begin
                    car_next = 1'b1;
                    if (nxt_kind == CK_R) begin
                        in_frame_n = 1'b0;
                        pend_r_n   = 1'b1;
                    end else begin
                        dv_n = 1'b1;
                        er_n = 1'b1;
                    end
                end
                default: begin
                    dv_n     = 1'b1;
                    er_n     = 1'b1;
                    car_next = 1'b1;
                end
            endcase
        end else begin
            if (cur_kind == CK_J && nxt_kind == CK_K) begin
                rxd_n      = NIB_SSD;
                dv_n       = 1'b1;
                car_next   = 1'b1;
                in_frame_n = 1'b1;
                pend_k_n   = 1'b1;
            end else if (cur_kind != CK_IDLE) begin
                er_n     = 1'b1;
                car_next = 1'b1;
            end
        end
    end

    // Frame state and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            pend_k   <= 1'b0;
            pend_r   <= 1'b0;
            rx_rxd   <= '0;
            rx_dv    <= 1'b0;
            rx_er    <= 1'b0;
        end else begin
            in_frame <= in_frame_n;
            pend_k   <= pend_k_n;
            pend_r   <= pend_r_n;
            rx_rxd   <= rxd_n;
            rx_dv    <= dv_n;
            rx_er    <= er_n;
        end
    end

    // R2: a frame start outside bypass always presents the 5h nibble.
    a_r2_start_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_dv) && !$past(bypass)) |-> (rx_rxd == NIB_SSD));

    // R2: the K time lasts exactly one symbol.
    a_r2_k_single: assert property (@(posedge clk) disable iff (!rst_n)
        pend_k |=> !pend_k);

endmodule

// File: rtl/rxsd_rx_decoder.sv
// Top of the receive symbol decoder: holds one code group of history,
// classifies it, runs the frame tracker and forms carrier sense from
// receive carrier plus the NIC-mode transmit term.
// Assumes rx_cg is aligned and descrambled, one code group per clock.
module rxsd_rx_decoder
    import rxsd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CG_W-1:0]  rx_cg,
    input  logic             tx_active,
    input  logic             rptr_mode,
    input  logic             bypass_4b5b,
    output logic [NIB_W-1:0] mii_rxd,
    output logic             mii_rx_dv,
    output logic             mii_rx_er,
    output logic             mii_crs
);

    logic [CG_W-1:0]  cur_cg;
    cg_kind_e         cur_kind;
    cg_kind_e         nxt_kind;
    logic [NIB_W-1:0] cur_nib;
    logic             car_next;

    // One symbol of history so pairs can be judged.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_cg <= CG_IDLE;
        else        cur_cg <= rx_cg;
    end

    // Kind of the arriving symbol, needed only for pair checks.
    always_comb nxt_kind = cg_kind_of(rx_cg);

    rxsd_cg_classify u_cls (
        .cg   (cur_cg),
        .kind (cur_kind),
        .nib  (cur_nib)
    );

    rxsd_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass   (bypass_4b5b),
        .cur_kind (cur_kind),
        .cur_nib  (cur_nib),
        .cur_raw  (cur_cg[NIB_W-1:0]),
        .nxt_kind (nxt_kind),
        .rx_rxd   (mii_rxd),
        .rx_dv    (mii_rx_dv),
        .rx_er    (mii_rx_er),
        .car_next (car_next)
    );

    // Carrier sense register: receive carrier, plus transmit in NIC mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mii_crs <= 1'b0;
        else        mii_crs <= car_next | (tx_active & ~rptr_mode);
    end

    // R4: data valid never appears without carrier.
    a_r4_dv_has_crs: assert property (@(posedge clk) disable iff (!rst_n)
        mii_rx_dv |-> mii_crs);

    // R9: NIC-mode transmit activity holds carrier on the next cycle.
    a_r9_tx_crs: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tx_active) && !$past(rptr_mode)) |-> mii_crs);

    // R10: bypass never reports a decode error.
    a_r10_bypass_no_er: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bypass_4b5b)) |-> !mii_rx_er);

endmodule

// File: tb/rxsd_rx_decoder_tb.sv
// Self-checking bench: sweeps every code group in and out of frames,
// in bypass, and with transmit activity in both carrier modes.
module rxsd_rx_decoder_tb_top;

    localparam logic [4:0] IDLE = 5'b11111, JC = 5'b11000, KC = 5'b10001,
                           TC = 5'b01101, RC = 5'b00111;
    localparam logic [4:0] TBL [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                        5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                        5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                        5'b11010, 5'b11011, 5'b11100, 5'b11101};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] rx_cg = IDLE;
    logic       tx_active = 1'b0, rptr_mode = 1'b0, bypass_4b5b = 1'b0;
    logic [3:0] mii_rxd;
    logic       mii_rx_dv, mii_rx_er, mii_crs;

    int n_tests = 0, n_fail = 0;
    logic [4:0] prev = IDLE;
    logic m_in = 1'b0, m_pk = 1'b0, m_pr = 1'b0;
    logic [3:0] e_rxd;
    logic e_dv, e_er, e_car;
    string tag;

    always #5 clk = ~clk;

    rxsd_rx_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .rx_cg(rx_cg), .tx_active(tx_active),
        .rptr_mode(rptr_mode), .bypass_4b5b(bypass_4b5b), .mii_rxd(mii_rxd),
        .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er), .mii_crs(mii_crs)
    );

    function automatic int data_index(input logic [4:0] c);
        int r = -1;
        for (int i = 0; i < 16; i++) if (TBL[i] == c) r = i;
        return r;
    endfunction

    // Expected outputs for held symbol p given the next symbol n.
    task automatic model(input logic [4:0] p, input logic [4:0] n);
        int pi = data_index(p);
        e_rxd = 4'h0; e_dv = 1'b0; e_er = 1'b0; e_car = 1'b0;
        if (bypass_4b5b) begin
            e_rxd = p[3:0]; e_dv = 1'b1; e_car = 1'b1;
            m_in = 1'b0; m_pk = 1'b0; m_pr = 1'b0; tag = "R10";
        end else if (m_pk) begin
            e_rxd = 4'h5; e_dv = 1'b1; e_car = 1'b1; m_pk = 1'b0; tag = "R2";
        end else if (m_pr) begin
            e_car = 1'b1; m_pr = 1'b0; tag = "R3";
        end else if (m_in) begin
            if (pi >= 0) begin
                e_rxd = pi[3:0]; e_dv = 1'b1; e_car = 1'b1; tag = "R1";
            end else if (p == IDLE) begin
                e_er = 1'b1; m_in = 1'b0; tag = "R7";
            end else if (p == TC && n == RC) begin
                e_car = 1'b1; m_in = 1'b0; m_pr = 1'b1; tag = "R3";
            end else if (p == TC) begin
                e_dv = 1'b1; e_er = 1'b1; e_car = 1'b1; tag = "R8";
            end else begin
                e_dv = 1'b1; e_er = 1'b1; e_car = 1'b1; tag = "R5";
            end
        end else begin
            if (p == IDLE) tag = "R4";
            else if (p == JC && n == KC) begin
                e_rxd = 4'h5; e_dv = 1'b1; e_car = 1'b1;
                m_in = 1'b1; m_pk = 1'b1; tag = "R2";
            end else begin
                e_er = 1'b1; e_car = 1'b1; tag = "R6";
            end
        end
        if (tx_active) tag = "R9";
    endtask

    task automatic check_out(input string t, input logic [3:0] xr,
                             input logic xd, input logic xe, input logic xc);
        n_tests++;
        if (mii_rxd !== xr || mii_rx_dv !== xd || mii_rx_er !== xe || mii_crs !== xc) begin
            n_fail++;
            $display("FAIL %s: rxd=%h dv=%b er=%b crs=%b expected rxd=%h dv=%b er=%b crs=%b",
                     t, mii_rxd, mii_rx_dv, mii_rx_er, mii_crs, xr, xd, xe, xc);
        end
    endtask

    // Drive one code group, advance one edge, compare at the falling edge.
    task automatic push(input logic [4:0] n);
        rx_cg = n;
        model(prev, n);
        prev = n;
        @(posedge clk);
        @(negedge clk);
        check_out(tag, e_rxd, e_dv, e_er, e_car | (tx_active & ~rptr_mode));
    endtask

    task automatic frame_with(input logic [4:0] c);
        push(JC); push(KC); push(TBL[3]); push(c); push(TBL[7]);
        push(TC); push(RC); push(IDLE); push(IDLE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R11", 4'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        // R4: idle stream
        repeat (4) push(IDLE);
        // R1, R2, R3: full frame carrying every nibble
        push(JC); push(KC);
        for (int i = 0; i < 16; i++) push(TBL[i]);
        push(TC); push(RC); push(IDLE); push(IDLE);
        // R5, R7, R8: every code group inside a frame
        for (int c = 0; c < 32; c++) frame_with(c[4:0]);
        // R6: every code group outside a frame
        for (int c = 0; c < 32; c++) begin
            push(IDLE); push(c[4:0]); push(IDLE); push(IDLE);
        end
        // R6: J followed by data
        push(JC); push(TBL[0]); push(IDLE); push(IDLE);
        // R7: premature end
        push(JC); push(KC); push(TBL[9]); push(IDLE); push(IDLE); push(IDLE);
        // R9: NIC mode, transmit holds carrier, also across a premature end
        tx_active = 1'b1;
        repeat (3) push(IDLE);
        push(JC); push(KC); push(TBL[2]); push(IDLE); push(IDLE); push(IDLE);
        // R9: repeater mode, transmit ignored
        rptr_mode = 1'b1;
        repeat (3) push(IDLE);
        frame_with(TBL[12]);
        tx_active = 1'b0; rptr_mode = 1'b0;
        push(IDLE);
        // R10: bypass entered mid-frame, then every code group raw
        push(JC); push(KC); push(TBL[4]);
        bypass_4b5b = 1'b1;
        for (int c = 0; c < 32; c++) push(c[4:0]);
        push(IDLE);
        bypass_4b5b = 1'b0;
        push(IDLE); push(IDLE);
        frame_with(TBL[15]);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule